// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block supervises a processor by watching a single watchdog line. Software toggles that line from time to time. If no transition reaches the block before the current timeout runs out, the block issues a reset pulse of fixed width. The pulse appears on an active-low output and also on an active-high output that always holds the opposite level. A one-clock flag marks each reset that a timeout started. The block runs from a slow free-running clock. A synchronous power-fail request stands in for a supply comparator. It holds reset active for as long as it is raised, and the pulse width is counted only after the request drops.

Two timeout lengths exist. After any reset the long timeout applies. The block moves to the short timeout only after software produces its first watchdog transition once reset has ended, because a processor that has just restarted may be slow to service the watchdog. A long-only select keeps the long timeout in force at all times. A disable level stops timeout resets altogether. A second select chooses between a short and a long reset pulse width.

Top module: `wdog_rst_supervisor`

## Requirements
- R1: While `pwr_fail_req` is sampled high, `rst_n_o` is 0, `rst_o` is 1 and `wd_timeout_o` is 0 from the next clock onward. A request raised during normal running also restarts the supervisor.
- R2: After `pwr_fail_req` drops, or after a timeout, reset stays active for exactly the pulse width. The width is 512 clocks when `pulse_long_sel`=0 and 2048 clocks when it is 1. Counting starts from the first clock at which the request is sampled low.
- R3: `rst_o` is always the inverse of `rst_n_o`.
- R4: With no watchdog transition after reset ends, reset becomes active again 4096 clocks after `rst_n_o` rises. If the line stays quiet, this repeats after every pulse.
- R5: Rising and falling transitions of `wd_in` both restart the count. A transition is acted on at the third clock edge after it appears, because it passes a two-flop synchronizer and an edge detector. The first transition after reset ends switches the block to the 1024-clock timeout, so reset then follows 1027 clocks after the final transition.
- R6: With `wd_long_only`=1, the timeout stays at 4096 clocks even after transitions.
- R7: While `wd_disable`=1, no timeout reset occurs and the count is held at zero. It counts a full timeout from zero after the disable is removed.
- R8: `wd_timeout_o` is high for exactly one clock, in the first clock in which a timeout-driven reset is active.
- R9: A transition that reaches the counter in the same clock as expiry wins. The count restarts and no reset is issued.
- R10: Transitions while reset is active are ignored. They neither select the short timeout nor shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow supervisor clock |
| pwr_fail_req | input | 1 | Synchronous power-fail request; holds reset active while high |
| wd_in | input | 1 | Watchdog activity line; both edges count |
| wd_disable | input | 1 | 1 = no timeout resets |
| wd_long_only | input | 1 | 1 = always use the long timeout |
| pulse_long_sel | input | 1 | Reset width select: 0 = 512 clocks, 1 = 2048 clocks |
| rst_n_o | output | 1 | Active-low reset |
| rst_o | output | 1 | Active-high reset, inverse of `rst_n_o` |
| wd_timeout_o | output | 1 | One-clock pulse when a timeout starts a reset |

## Verification
Two events can land on the same clock: a synchronized watchdog transition and the expiry of the short timeout. The bench provokes this by toggling the line exactly 1024 clocks after the previous toggle several times in a row. It then judges that reset never goes active during that run. The bench's behavioural model, which applies transitions before expiry, must agree with the outputs on every clock. A quiet period that follows then confirms that expiry still fires 1027 clocks after the last toggle.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

   // counter width able to hold values 0 .. n-1
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   typedef enum logic {
      TO_SEL_SHORT = 1'b0,
      TO_SEL_LONG  = 1'b1
   } to_sel_e;

endpackage

// File: rtl/wdsup_edge_sync.sv
module wdsup_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic edg_o
);
   // pipe[0..STAGES-1] synchronize, pipe[STAGES] holds previous synchronized value
   logic [STAGES:0] pipe;

   always_ff @(posedge clk) begin
      if (clr) pipe[0] <= 1'b0;
      else     pipe[0] <= din;
   end

   for (genvar gi = 1; gi <= STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
         if (clr) pipe[gi] <= 1'b0;
         else     pipe[gi] <= pipe[gi-1];
      end
   end

   assign edg_o = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/wdsup_wd_timer.sv
module wdsup_wd_timer
   import wdsup_pkg::*;
#(
   parameter int unsigned TO_SHORT = 1024,
   parameter int unsigned TO_LONG  = 4096
) (
   input  logic clk,
   input  logic hold,
   input  logic act_edge,
   input  logic wd_off,
   input  logic long_only,
   output logic expire_o
);
   localparam int unsigned CW = cnt_bits(TO_LONG);
   localparam logic [CW-1:0] LIM_SHORT = CW'(TO_SHORT - 1);
   localparam logic [CW-1:0] LIM_LONG  = CW'(TO_LONG - 1);

   logic [CW-1:0] cnt_q;
   logic          short_ok_q;
   to_sel_e       sel;
   logic [CW-1:0] lim;

   assign sel = (short_ok_q && !long_only) ? TO_SEL_SHORT : TO_SEL_LONG;
   assign lim = (sel == TO_SEL_SHORT) ? LIM_SHORT : LIM_LONG;

   // a transition in the expiring cycle wins over expiry
   assign expire_o = !hold && !act_edge && !wd_off && (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (hold || act_edge || wd_off || expire_o) cnt_q <= '0;
      else                                        cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (hold)          short_ok_q <= 1'b0;
      else if (act_edge) short_ok_q <= 1'b1;
   end
endmodule

// File: rtl/wdsup_rst_pulse.sv
module wdsup_rst_pulse
   import wdsup_pkg::*;
#(
   parameter int unsigned PW_SHORT = 512,
   parameter int unsigned PW_LONG  = 2048
) (
   input  logic clk,
   input  logic hold,
   input  logic fire,
   input  logic long_sel,
   output logic active_o,
   output logic active_n_o
);
   localparam int unsigned CW = cnt_bits(max_u(PW_SHORT, PW_LONG));
   localparam logic [CW-1:0] END_SHORT = CW'(PW_SHORT - 1);
   localparam logic [CW-1:0] END_LONG  = CW'(PW_LONG - 1);

   logic [CW-1:0] cnt_q;
   logic          act_d;
   logic [CW-1:0] cnt_d;
   logic [CW-1:0] last;

   assign last = long_sel ? END_LONG : END_SHORT;

   always_comb begin
      act_d = active_o;
      cnt_d = cnt_q;
      if (hold || fire) begin
         act_d = 1'b1;
         cnt_d = '0;
      end else if (active_o) begin
         if (cnt_q >= last) act_d = 1'b0;
         else               cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      cnt_q      <= cnt_d;
      active_o   <= act_d;
      active_n_o <= !act_d;
   end
endmodule

// File: rtl/wdog_rst_supervisor.sv
module wdog_rst_supervisor #(
   parameter int unsigned TO_SHORT    = 1024,
   parameter int unsigned TO_LONG     = 4096,
   parameter int unsigned PW_SHORT    = 512,
   parameter int unsigned PW_LONG     = 2048,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic pwr_fail_req,
   input  logic wd_in,
   input  logic wd_disable,
   input  logic wd_long_only,
   input  logic pulse_long_sel,
   output logic rst_n_o,
   output logic rst_o,
   output logic wd_timeout_o
);
   if (TO_SHORT < 2 || TO_LONG < TO_SHORT) begin : g_bad_timeout
      $error("timeout lengths must satisfy 2 <= TO_SHORT <= TO_LONG");
   end
   if (PW_SHORT < 1 || PW_LONG < 1) begin : g_bad_width
      $error("pulse widths must be at least one clock");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs two or more stages");
   end

   logic act_edge;
   logic expire;
   logic pulse_active;
   logic wd_hold;
   logic flag_q;

   assign wd_hold = pwr_fail_req || pulse_active;

   wdsup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr   (pwr_fail_req),
      .din   (wd_in),
      .edg_o (act_edge)
   );

   wdsup_wd_timer #(.TO_SHORT(TO_SHORT), .TO_LONG(TO_LONG)) u_timer (
      .clk       (clk),
      .hold      (wd_hold),
      .act_edge  (act_edge),
      .wd_off    (wd_disable),
      .long_only (wd_long_only),
      .expire_o  (expire)
   );

   wdsup_rst_pulse #(.PW_SHORT(PW_SHORT), .PW_LONG(PW_LONG)) u_pulse (
      .clk        (clk),
      .hold       (pwr_fail_req),
      .fire       (expire),
      .long_sel   (pulse_long_sel),
      .active_o   (pulse_active),
      .active_n_o (rst_n_o)
   );

   always_ff @(posedge clk) begin
      flag_q <= expire;
   end

   assign rst_o        = pulse_active;
   assign wd_timeout_o = flag_q;
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker (
   input logic clk,
   input logic pwr_fail_req,
   input logic wd_disable,
   input logic rst_n_o,
   input logic rst_o,
   input logic wd_timeout_o
);
   logic armed_q = 1'b0;
   always_ff @(posedge clk) begin
      if (pwr_fail_req) armed_q <= 1'b1;
   end

   a_r1_req_holds: assert property (@(posedge clk) disable iff (!armed_q)
      pwr_fail_req |=> (!rst_n_o && rst_o && !wd_timeout_o));

   a_r3_complement: assert property (@(posedge clk) disable iff (!armed_q)
      rst_o == !rst_n_o);

   a_r2_only_causes: assert property (@(posedge clk) disable iff (!armed_q)
      (!pwr_fail_req && rst_n_o) |=> (rst_n_o || wd_timeout_o));

   a_r7_disabled: assert property (@(posedge clk) disable iff (!armed_q)
      wd_disable |=> !wd_timeout_o);

   a_r8_single: assert property (@(posedge clk) disable iff (!armed_q)
      wd_timeout_o |=> !wd_timeout_o);

   a_r8_with_rst: assert property (@(posedge clk) disable iff (!armed_q)
      wd_timeout_o |-> !rst_n_o);
endmodule

bind wdog_rst_supervisor wdsup_checker u_chk (
   .clk          (clk),
   .pwr_fail_req (pwr_fail_req),
   .wd_disable   (wd_disable),
   .rst_n_o      (rst_n_o),
   .rst_o        (rst_o),
   .wd_timeout_o (wd_timeout_o)
);

// File: tb/wdog_rst_supervisor_tb.sv
module wdog_rst_supervisor_tb;
   localparam int CLK_P = 10;
   localparam int TO_S = 1024, TO_L = 4096, PW_S = 512, PW_L = 2048;

   logic clk = 1'b0;
   logic req = 1'b1, wd = 1'b0, dis = 1'b0, lo = 1'b0, wsel = 1'b0;
   logic rst_n_o, rst_o, wd_timeout_o;

   int n_chk = 0, n_fail = 0, n_printed = 0;
   string phase = "R1";
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   wdog_rst_supervisor u_dut (
      .clk(clk), .pwr_fail_req(req), .wd_in(wd), .wd_disable(dis),
      .wd_long_only(lo), .pulse_long_sel(wsel),
      .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_timeout_o(wd_timeout_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         if (n_printed < 30) begin
            n_printed++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
         end
      end
   endtask

   // behavioural reference: history queue of sampled wd values, integer counters
   bit   m_valid = 0;
   bit   m_act, m_short, m_flag;
   int   m_wc, m_rc;
   bit   hist[$];

   always @(posedge clk) begin
      bit e, fire; int lim, w;
      if (req) begin
         m_valid = 1; m_act = 1; m_rc = 0; m_wc = 0; m_short = 0; m_flag = 0;
         hist = '{0, 0, 0};
      end else if (m_valid) begin
         e    = hist[1] != hist[2];
         lim  = (m_short && !lo) ? TO_S : TO_L;
         fire = !m_act && !e && !dis && (m_wc == lim - 1);
         w    = wsel ? PW_L : PW_S;
         if (m_act) m_short = 0; else if (e) m_short = 1;
         m_wc = (m_act || e || dis || fire) ? 0 : m_wc + 1;
         if (fire) begin m_act = 1; m_rc = 0; end
         else if (m_act) begin
            if (m_rc >= w - 1) m_act = 0; else m_rc++;
         end
         m_flag = fire;
         hist.push_front(wd);
         void'(hist.pop_back());
      end
   end

   // every-clock comparison, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (m_valid && !done) begin
         chk(rst_n_o == !m_act, {phase, " rst_n_o vs model"}, rst_n_o, !m_act);
         chk(rst_o == !rst_n_o, "R3 complement", rst_o, !rst_n_o);
         chk(wd_timeout_o == m_flag, {phase, " R8 flag vs model"}, wd_timeout_o, m_flag);
      end
   end

   task automatic count_rise(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!rst_n_o && n < 20000);
   endtask

   task automatic count_fall(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (rst_n_o && n < 20000);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in phase %s actual=%0d expected=%0d", phase, 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      repeat (5) @(negedge clk);
      chk(rst_n_o == 0 && rst_o == 1 && wd_timeout_o == 0, "R1 reset state", rst_n_o, 0);

      phase = "R2"; req = 0;
      count_rise(n); chk(n == PW_S, "R2 short width after request", n, PW_S);

      phase = "R4";
      count_fall(n); chk(n == TO_L, "R4 long timeout after reset", n, TO_L);
      chk(wd_timeout_o == 1, "R8 flag with timeout reset", wd_timeout_o, 1);
      @(negedge clk); chk(wd_timeout_o == 0, "R8 flag one clock", wd_timeout_o, 0);
      count_rise(n); chk(n == PW_S - 1, "R2 width after timeout", n + 1, PW_S);
      count_fall(n); chk(n == TO_L, "R4 repeats with quiet line", n, TO_L);
      count_rise(n);

      phase = "R5";
      for (int k = 0; k < 5; k++) begin wd = ~wd; repeat (600) @(negedge clk); end
      chk(rst_n_o == 1, "R5 toggling keeps reset off", rst_n_o, 1);
      wd = ~wd;
      count_fall(n); chk(n == TO_S + 3, "R5 short timeout after last edge", n, TO_S + 3);
      count_rise(n);

      phase = "R9";
      wd = ~wd;
      for (int k = 0; k < 6; k++) begin repeat (TO_S) @(negedge clk); wd = ~wd; end
      chk(rst_n_o == 1, "R9 edge wins at expiry", rst_n_o, 1);
      count_fall(n); chk(n == TO_S + 3, "R9 expiry after final edge", n, TO_S + 3);
      count_rise(n);

      phase = "R2";
      wsel = 1; req = 1; repeat (3) @(negedge clk);
      chk(rst_n_o == 0, "R1 request during run", rst_n_o, 0);
      req = 0;
      count_rise(n); chk(n == PW_L, "R2 long width", n, PW_L);

      phase = "R10";
      wsel = 0; req = 1; repeat (3) @(negedge clk); req = 0;
      repeat (10) @(negedge clk); wd = ~wd;
      repeat (10) @(negedge clk); wd = ~wd;
      count_rise(n); chk(n == PW_S - 20, "R10 edges do not shorten pulse", n + 20, PW_S);
      count_fall(n); chk(n == TO_L, "R10 long timeout kept", n, TO_L);
      count_rise(n);

      phase = "R6";
      lo = 1; wd = ~wd;
      count_fall(n); chk(n == TO_L + 3, "R6 long-only timeout", n, TO_L + 3);
      count_rise(n); lo = 0;

      phase = "R7";
      dis = 1; repeat (10000) @(negedge clk);
      chk(rst_n_o == 1 && wd_timeout_o == 0, "R7 no reset while disabled", rst_n_o, 1);
      dis = 0;
      count_fall(n); chk(n == TO_L, "R7 full count after enable", n, TO_L);
      count_rise(n);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule